// File: doc/BRIEF.md
# Subblocked Write-Through Store Path

This block is the store side of a direct-mapped, write-through cache whose lines are split into one-word subblocks, each with its own valid bit. A store never waits for a line fill and never reads the array first. It writes its word and its tag into the line in the cycle it is accepted. It then repairs the line's valid bits from the result of the tag compare. If the tags match, the stored word's bit is set and the other bits are kept. If they differ, the stored word's bit is the only one left set.

Because the cache is write-through, memory always holds a current copy. Overwriting the tag on a mismatch therefore loses nothing. The same store is handed to memory through a valid/ready request. The store is accepted only in a cycle where memory accepts that request, so a busy memory stalls the store and leaves the arrays untouched. A combinational lookup port reports, for any address, whether a read would hit and which word is held there.

Word addresses are split into three fields. Bits [1:0] select the subblock, bits [7:2] select one of 64 lines, and the remaining upper bits form the tag.

Top module: `sbwt_store_path`

## Requirements
- R1: After reset every address looks up as a miss (lk_hit = 0).
- R2: mem_wr_valid, mem_wr_addr and mem_wr_data equal st_valid, st_addr and st_data in the same cycle.
- R3: st_ready equals mem_wr_ready. A store offered while mem_wr_ready = 0 changes no tag, valid bit or word, so lookups are unchanged afterwards.
- R4: An accepted store writes its word and its tag into the line at once, whatever the hit result. From the next cycle a lookup of the same address hits and returns the stored word.
- R5: Tag match with the subblock already valid: the bit stays set, the word is replaced, and the other subblocks keep their state and data.
- R6: Tag match with the subblock invalid: its bit is set, and the other subblocks' valid bits are unchanged.
- R7: Tag mismatch: the tag is replaced, the stored subblock becomes valid and every other subblock of that line becomes invalid. Addresses under the old tag then miss.
- R8: A store changes only the line selected by address bits [7:2]. All other lines look up as before.
- R9: A lookup hits only when the stored tag of the line equals address bits above bit 7 and the addressed subblock's valid bit is set. lk_data returns the word held for that subblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all valid bits |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle when st_valid is high |
| st_addr | input | 16 | Store word address |
| st_data | input | 32 | Store word |
| mem_wr_valid | output | 1 | Write-through request to memory |
| mem_wr_ready | input | 1 | Memory accepts the request |
| mem_wr_addr | output | 16 | Request word address |
| mem_wr_data | output | 32 | Request word |
| lk_addr | input | 16 | Lookup word address |
| lk_hit | output | 1 | Lookup would hit |
| lk_data | output | 32 | Word held at the lookup subblock |

## Verification
Every one of the 64 lines is taken through the same walk. The first store lands in an empty line. A second store to a new subblock with the same tag exercises the match-but-invalid case. Overwriting the first word exercises the match-and-valid case. A store under a flipped tag exercises the mismatch case. After each store all four subblocks are looked up, under both the current tag and a wrong tag, so an invalidation that is too narrow or too wide is exposed. So is a tag compare that ignores bits. Whole-array sweeps after the walk catch a store that spills into a neighbouring line. A stalled-memory pattern, with the store held for several cycles while ready is low, separates acceptance from mere presentation.

// File: rtl/sbwt_store_path.sv
module sbwt_store_path #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int SUBS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data
);
  localparam int OFF_W = $clog2(SUBS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [LINES-1:0][SUBS-1:0]  vld_q;
  logic [LINES-1:0][TAG_W-1:0] tag_q;
  logic [DATA_W-1:0]           data_q [LINES*SUBS];

  wire [OFF_W-1:0] st_off = st_addr[OFF_W-1:0];
  wire [IDX_W-1:0] st_idx = st_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] st_tag = st_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] lk_off = lk_addr[OFF_W-1:0];
  wire [IDX_W-1:0] lk_idx = lk_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] lk_tag = lk_addr[ADDR_W-1 -: TAG_W];

  wire fire    = st_valid && mem_wr_ready;
  wire tag_hit = (tag_q[st_idx] == st_tag);

  logic [SUBS-1:0] sel, nxt_vb;
  always_comb begin
    sel         = '0;
    sel[st_off] = 1'b1;
    nxt_vb      = tag_hit ? (vld_q[st_idx] | sel) : sel;
  end

  assign st_ready     = mem_wr_ready;
  assign mem_wr_valid = st_valid;
  assign mem_wr_addr  = st_addr;
  assign mem_wr_data  = st_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vld_q <= '0;
    else if (fire) vld_q[st_idx] <= nxt_vb;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      tag_q[st_idx]           <= st_tag;
      data_q[{st_idx, st_off}] <= st_data;
    end
  end

  assign lk_hit  = (tag_q[lk_idx] == lk_tag) && vld_q[lk_idx][lk_off];
  assign lk_data = data_q[{lk_idx, lk_off}];
endmodule

// File: rtl/sbwt_store_path_chk.sv
module sbwt_store_path_chk #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 64,
  parameter int SUBS   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic st_valid,
  input logic mem_wr_ready,
  input logic [ADDR_W-1:0] st_addr,
  input logic [LINES-1:0][SUBS-1:0] vld,
  input logic [LINES-1:0][ADDR_W-$clog2(SUBS)-$clog2(LINES)-1:0] tags
);
  localparam int OFF_W = $clog2(SUBS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic             p_fire, p_match;
  logic [IDX_W-1:0] p_idx;
  logic [OFF_W-1:0] p_off;
  logic [TAG_W-1:0] p_tag;
  logic [SUBS-1:0]  p_vb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_fire <= 1'b0; p_match <= 1'b0; p_idx <= '0; p_off <= '0; p_tag <= '0; p_vb <= '0;
    end else begin
      p_fire  <= st_valid && mem_wr_ready;
      p_idx   <= st_addr[OFF_W +: IDX_W];
      p_off   <= st_addr[OFF_W-1:0];
      p_tag   <= st_addr[ADDR_W-1 -: TAG_W];
      p_match <= tags[st_addr[OFF_W +: IDX_W]] == st_addr[ADDR_W-1 -: TAG_W];
      p_vb    <= vld[st_addr[OFF_W +: IDX_W]];
    end
  end

  a_r4_word_and_tag_land: assert property (@(posedge clk) disable iff (!rst_n)
    p_fire |-> (tags[p_idx] == p_tag) && vld[p_idx][p_off]);

  a_r7_mismatch_leaves_one: assert property (@(posedge clk) disable iff (!rst_n)
    (p_fire && !p_match) |-> vld[p_idx] == (SUBS'(1) << p_off));

  a_r6_match_adds_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (p_fire && p_match) |-> vld[p_idx] == (p_vb | (SUBS'(1) << p_off)));

  a_r3_stall_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_valid && mem_wr_ready) |=> $stable(vld) && $stable(tags));
endmodule

bind sbwt_store_path sbwt_store_path_chk #(.ADDR_W(ADDR_W), .LINES(LINES), .SUBS(SUBS)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .mem_wr_ready(mem_wr_ready),
  .st_addr(st_addr), .vld(vld_q), .tags(tag_q)
);

// File: tb/sbwt_store_path_tb.sv
module sbwt_store_path_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 64;
  localparam int SUBS  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [15:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b1;
  logic [15:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic [15:0] lk_addr = '0;
  logic        lk_hit;
  logic [31:0] lk_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  m_tag  [LINES];
  bit          m_tknown [LINES];
  logic [3:0]  m_vld  [LINES];
  logic [31:0] m_data [LINES*SUBS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbwt_store_path u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
  );

  function automatic logic [15:0] mk(input logic [7:0] tag, input int idx, input int off);
    return {tag, 6'(idx), 2'(off)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [7:0] tag, input int idx, input int off, input string req);
    bit eh;
    @(negedge clk);
    lk_addr = mk(tag, idx, off);
    #1;
    eh = m_tknown[idx] && (m_tag[idx] == tag) && m_vld[idx][off];
    chk(lk_hit == eh, req, lk_hit, eh);
    if (eh) chk(lk_data == m_data[idx*SUBS+off], req, lk_data, m_data[idx*SUBS+off]);
  endtask

  task automatic look_line(input logic [7:0] tag, input int idx, input string req);
    for (int o = 0; o < SUBS; o++) begin
      look(tag, idx, o, req);
      look(tag ^ 8'h81, idx, o, "R9 wrong tag");
    end
  endtask

  task automatic store(input logic [7:0] tag, input int idx, input int off, input logic [31:0] d);
    logic [3:0] sel;
    @(negedge clk);
    st_valid = 1'b1; st_addr = mk(tag, idx, off); st_data = d;
    #1;
    chk(mem_wr_valid && mem_wr_addr == st_addr && mem_wr_data == d, "R2 mirror",
        {mem_wr_valid, mem_wr_addr, mem_wr_data}, {1'b1, st_addr, d});
    chk(st_ready == mem_wr_ready, "R3 ready", st_ready, mem_wr_ready);
    @(posedge clk);
    sel = 4'b1 << off;
    if (m_tknown[idx] && m_tag[idx] == tag) m_vld[idx] = m_vld[idx] | sel;
    else m_vld[idx] = sel;
    m_tag[idx] = tag; m_tknown[idx] = 1'b1;
    m_data[idx*SUBS+off] = d;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < LINES; i++)
      for (int o = 0; o < SUBS; o++) look(m_tag[i], i, o, req);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin m_tag[i] = '0; m_tknown[i] = 1'b0; m_vld[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < LINES; i++)
      for (int o = 0; o < SUBS; o++) begin
        @(negedge clk); lk_addr = mk(8'h00, i, o); #1;
        chk(lk_hit == 1'b0, "R1 reset miss", lk_hit, 0);
        lk_addr = mk(8'hA5, i, o); #1;
        chk(lk_hit == 1'b0, "R1 reset miss", lk_hit, 0);
      end

    for (int i = 0; i < LINES; i++) begin
      logic [7:0] t;
      t = 8'(i) ^ 8'h33;
      store(t, i, i % SUBS, 32'h1000_0000 + i);
      look_line(t, i, "R4 first store");
      store(t, i, (i + 1) % SUBS, 32'h2000_0000 + i);
      look_line(t, i, "R6 match invalid");
      store(t, i, i % SUBS, 32'h3000_0000 + i * 7);
      look_line(t, i, "R5 match valid");
      store(t, i, (i + 3) % SUBS, 32'h4000_0000 + i);
      look_line(t, i, "R6 third bit");
    end
    sweep("R8 lines independent");

    for (int i = 0; i < LINES; i++) begin
      logic [7:0] t;
      t = m_tag[i];
      store(t ^ 8'hFF, i, (i + 2) % SUBS, 32'h5000_0000 + i);
      look_line(t ^ 8'hFF, i, "R7 mismatch");
      for (int o = 0; o < SUBS; o++) look(t, i, o, "R7 old tag misses");
    end
    sweep("R8 lines independent");

    mem_wr_ready = 1'b0;
    @(negedge clk);
    st_valid = 1'b1; st_addr = mk(8'h77, 5, 1); st_data = 32'hDEAD_BEEF;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(st_ready == 1'b0 && mem_wr_valid == 1'b1, "R3 stall", {st_ready, mem_wr_valid}, 2'b01);
    end
    st_valid = 1'b0;
    mem_wr_ready = 1'b1;
    look_line(m_tag[5], 5, "R3 stalled store ignored");
    look(8'h77, 5, 1, "R3 stalled store ignored");
    store(8'h77, 5, 1, 32'hDEAD_BEEF);
    look_line(8'h77, 5, "R7 after stall");
    sweep("R8 final");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule